// File: doc/BRIEF.md
# Power Switchover Time Stamp

This block records when a system's supply source changes. It watches a power-source level (high while running from the backup battery, low while on the main supply). On each change it copies the live calendar fields into one of two five-byte records: minute, hour, date, month and year, kept in the calendar's own BCD byte format.

The two records follow different rules. The switch-to-battery record keeps only the first switch after it was last cleared, so it shows when the system first lost main power. The return-to-main record is rewritten on every return, so it shows the most recent restore.

Software reads both records through a byte-wide register read port. Setting the clear bit in the power control register empties both records, and the bit drops back to zero by itself one cycle later. The power-source level is synchronised inside the block, so it may come from an asynchronous comparator.

Top module: `pss_top`

## Requirements
- R1: After reset, every byte of both records reads 00h.
- R2: On the first low-to-high change of `on_batt` since reset or the last clear, the calendar bytes are stored in the switch-to-battery record at addresses 16h (minute), 17h (hour), 18h (date), 19h (month) and 1Ah (year). The calendar is sampled at the SYNC_STAGES-th rising clock edge after the first edge that sees the new level.
- R3: Further low-to-high changes of `on_batt` leave the switch-to-battery record unchanged until a clear happens.
- R4: Every high-to-low change of `on_batt` overwrites the return-to-main record at 1Bh (minute), 1Ch (hour), 1Dh (date), 1Eh (month) and 1Fh (year), with the same sampling time as R2.
- R5: A write to address 09h with data bit 7 set sets a clear bit for exactly one cycle. During that cycle both records are zeroed and the switch-to-battery record becomes free to capture again.
- R6: Writes to any other address, and writes to 09h with bit 7 clear, change neither record.
- R7: When a capture and a clear fall in the same cycle, the capturing record takes the calendar value and the other record is zeroed. A switch-to-battery capture in that cycle succeeds even if the record was already occupied.
- R8: Read addresses outside 16h–1Fh return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_batt | input | 1 | Asynchronous power source level, 1 = backup battery |
| cal_min | input | 8 | Live minute, BCD |
| cal_hour | input | 8 | Live hour, BCD |
| cal_date | input | 8 | Live date, BCD |
| cal_month | input | 8 | Live month, BCD |
| cal_year | input | 8 | Live year, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. A deeper chain moves the capture cycle, so the bench's latency arithmetic is tested on a value other than the default. It also lets the bench time a clear write to land in exactly the capture cycle, which reaches the priority case of R7. The remaining address and calendar parameters stay at their defaults, so the 09h and 16h–1Fh decoding is checked as specified.

// File: rtl/pss_pkg.sv
// Shared types for the power switchover time stamp.
// Assumes every calendar field fits in one BCD byte.
package pss_pkg;
    localparam int FIELD_W  = 8;
    localparam int N_FIELDS = 5;   // minute, hour, date, month, year
    typedef logic [N_FIELDS-1:0][FIELD_W-1:0] stamp_t;
endpackage

// File: rtl/pss_sync.sv
// Brings the asynchronous power-source level into the clock domain and
// flags its edges. Assumes STAGES >= 1. The reset value is 0, meaning main
// supply, so a battery level present at reset release reads as a switch.
module pss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              level;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic d;
        if (g == 0) begin : g_first
            assign d = async_i;
        end else begin : g_next
            assign d = chain_q[g-1];
        end
        // Shift one synchroniser stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= d;
        end
    end

    assign level = chain_q[STAGES-1];

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise_o = level & ~prev_q;
    assign fall_o = ~level & prev_q;

    // R2
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));
    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pss_bank.sv
// One five-byte time stamp record. With FIRST_ONLY=1 it keeps the first
// capture until cleared; with FIRST_ONLY=0 every capture overwrites it.
// Assumes cap_i and clr_i are single-cycle pulses from the same clock.
module pss_bank #(
    parameter bit FIRST_ONLY = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_i,
    input  logic            clr_i,
    input  pss_pkg::stamp_t cal_i,
    output pss_pkg::stamp_t rec_o
);
    pss_pkg::stamp_t rec_q;
    logic            vld_q;
    logic            take;

    if (FIRST_ONLY) begin : g_first
        // A clear in the same cycle frees the record, so the capture wins.
        assign take = cap_i && (!vld_q || clr_i);

        // R3
        frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q && !clr_i) |=> $stable(rec_q));
    end else begin : g_last
        assign take = cap_i;

        // R4
        overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_i |=> (rec_q == $past(cal_i)));
    end

    // Capture has priority over clear; clear empties the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
            vld_q <= 1'b0;
        end else if (take) begin
            rec_q <= cal_i;
            vld_q <= 1'b1;
        end else if (clr_i) begin
            rec_q <= '0;
            vld_q <= 1'b0;
        end
    end

    assign rec_o = rec_q;

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cap_i) |=> (rec_q == '0 && !vld_q));
    // R7
    clear_vs_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && cap_i) |=> (vld_q && rec_q == $past(cal_i)));
endmodule

// File: rtl/pss_regif.sv
// Register side: decodes the self-clearing clear bit from writes and muxes
// the ten record bytes onto the read port. Assumes single-cycle write strobes.
module pss_regif #(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h09,
    parameter int                CLR_BIT   = 7,
    parameter logic [ADDR_W-1:0] BATT_BASE = 6'h16,
    parameter logic [ADDR_W-1:0] MAIN_BASE = 6'h1B
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [pss_pkg::FIELD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  pss_pkg::stamp_t            batt_rec,
    input  pss_pkg::stamp_t            main_rec,
    output logic                       clr_o,
    output logic [pss_pkg::FIELD_W-1:0] rd_data
);
    logic clr_q;
    logic ctrl_hit;

    assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);

    // Clear bit: set by a write, back to zero one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= ctrl_hit && wr_data[CLR_BIT];
    end

    assign clr_o = clr_q;

    // Read mux over both records; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        for (int f = 0; f < pss_pkg::N_FIELDS; f++) begin
            if (rd_addr == ADDR_W'(int'(BATT_BASE) + f)) rd_data = batt_rec[f];
            if (rd_addr == ADDR_W'(int'(MAIN_BASE) + f)) rd_data = main_rec[f];
        end
    end

    // R5
    clr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && wr_data[CLR_BIT]) |=> clr_o);
    // R6
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_hit && wr_data[CLR_BIT]) |=> !clr_o);
endmodule

// File: rtl/pss_top.sv
// Power switchover time stamp: a first-event record for switches to battery
// and a last-event record for returns to main supply, sharing one clear bit.
// Assumes the calendar inputs are stable around a capture cycle.
module pss_top #(
    parameter int                SYNC_STAGES = 2,
    parameter int                ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 6'h09,
    parameter int                CLR_BIT     = 7,
    parameter logic [ADDR_W-1:0] BATT_BASE   = 6'h16,
    parameter logic [ADDR_W-1:0] MAIN_BASE   = 6'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_batt,
    input  logic [7:0]        cal_min,
    input  logic [7:0]        cal_hour,
    input  logic [7:0]        cal_date,
    input  logic [7:0]        cal_month,
    input  logic [7:0]        cal_year,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    pss_pkg::stamp_t cal;
    pss_pkg::stamp_t batt_rec;
    pss_pkg::stamp_t main_rec;
    logic            go_batt;
    logic            go_main;
    logic            clr;

    assign cal = {cal_year, cal_month, cal_date, cal_hour, cal_min};

    pss_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(on_batt),
        .rise_o(go_batt), .fall_o(go_main)
    );

    pss_bank #(.FIRST_ONLY(1'b1)) i_batt (
        .clk(clk), .rst_n(rst_n), .cap_i(go_batt), .clr_i(clr),
        .cal_i(cal), .rec_o(batt_rec)
    );

    pss_bank #(.FIRST_ONLY(1'b0)) i_main (
        .clk(clk), .rst_n(rst_n), .cap_i(go_main), .clr_i(clr),
        .cal_i(cal), .rec_o(main_rec)
    );

    pss_regif #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CLR_BIT(CLR_BIT),
        .BATT_BASE(BATT_BASE), .MAIN_BASE(MAIN_BASE)
    ) i_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .batt_rec(batt_rec),
        .main_rec(main_rec), .clr_o(clr), .rd_data(rd_data)
    );

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (batt_rec == '0 && main_rec == '0));
    // R6
    quiet_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_main && !clr) |=> $stable(main_rec));
endmodule

// File: tb/test_pss_top.sv
module test_pss_top;
    localparam int S = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       on_batt = 1'b0;
    logic [7:0] cal_min = '0, cal_hour = '0, cal_date = '0, cal_month = '0, cal_year = '0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] exp_b [5];
    logic [7:0] exp_m [5];
    bit   b_vld;

    always #4 clk = ~clk;

    pss_top #(.SYNC_STAGES(S)) i_pss_top (
        .clk(clk), .rst_n(rst_n), .on_batt(on_batt),
        .cal_min(cal_min), .cal_hour(cal_hour), .cal_date(cal_date),
        .cal_month(cal_month), .cal_year(cal_year),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check_rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        n_chk++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s addr=%0h actual=%0h expected=%0h", tag, a, rd_data, e);
        end
    endtask

    task automatic check_all(input string tag);
        for (int f = 0; f < 5; f++) begin
            check_rd(6'(8'h16 + f), exp_b[f], tag);
            check_rd(6'(8'h1B + f), exp_m[f], tag);
        end
    endtask

    task automatic new_cal();
        cal_min   = bcd(int'($urandom % 60));
        cal_hour  = bcd(int'($urandom % 24));
        cal_date  = bcd(1 + int'($urandom % 31));
        cal_month = bcd(1 + int'($urandom % 12));
        cal_year  = bcd(int'($urandom % 100));
    endtask

    task automatic model_cap(input bit to_batt, input bit force_b);
        logic [7:0] c [5];
        c = '{cal_min, cal_hour, cal_date, cal_month, cal_year};
        if (to_batt) begin
            if (!b_vld || force_b) begin
                exp_b = c;
                b_vld = 1'b1;
            end
        end else begin
            exp_m = c;
        end
    endtask

    task automatic model_clr();
        for (int f = 0; f < 5; f++) begin
            exp_b[f] = '0;
            exp_m[f] = '0;
        end
        b_vld = 1'b0;
    endtask

    // Change the supply source with a fresh calendar and wait out the latency.
    task automatic toggle_power();
        @(negedge clk);
        new_cal();
        on_batt = ~on_batt;
        repeat (S + 2) @(negedge clk);
        model_cap(on_batt, 1'b0);
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        if (a == 6'h09 && d[7]) model_clr();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_all("R1");
        // R8 unmapped addresses
        check_rd(6'h15, 8'h00, "R8");
        check_rd(6'h20, 8'h00, "R8");
        check_rd(6'h09, 8'h00, "R8");

        // R2 first switch to battery
        toggle_power();
        check_all("R2");
        // R4 return to main
        toggle_power();
        check_all("R4");
        // R3 second switch to battery is ignored
        toggle_power();
        check_all("R3");
        toggle_power();
        check_all("R4");
        check_rd(6'h15, 8'h00, "R8");
        check_rd(6'h20, 8'h00, "R8");
        // R6 bit 7 clear and other addresses change nothing
        reg_write(6'h09, 8'h7F);
        check_all("R6");
        reg_write(6'h0A, 8'hFF);
        check_all("R6");
        // R5 clear empties both records, then a new first capture works
        reg_write(6'h09, 8'h80);
        check_all("R5");
        toggle_power();
        check_all("R5");
        toggle_power();

        // R7 clear lands in the battery capture cycle while occupied
        @(negedge clk);
        new_cal();
        on_batt = 1'b1;
        repeat (S - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'h09; wr_data = 8'h80;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        model_clr();
        model_cap(1'b1, 1'b1);
        check_all("R7");

        // R7 clear lands in the main capture cycle
        @(negedge clk);
        new_cal();
        on_batt = 1'b0;
        repeat (S - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'h09; wr_data = 8'hC3;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        model_clr();
        model_cap(1'b0, 1'b0);
        check_all("R7");

        // Random mix across R2 R3 R4 R5 R6
        for (int i = 0; i < 60; i++) begin
            int op;
            op = int'($urandom % 4);
            if (op < 2) begin
                toggle_power();
                check_all(on_batt ? "R3" : "R4");
            end else if (op == 2) begin
                reg_write(6'h09, 8'($urandom));
                check_all("R5");
            end else begin
                logic [5:0] a;
                a = 6'($urandom);
                if (a == 6'h09) a = 6'h0B;
                reg_write(a, 8'($urandom));
                check_all("R6");
            end
        end
        check_rd(6'h3F, 8'h00, "R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule